// File: doc/BRIEF.md
# Dual-Mode Serial Register Slave

This block gives a register file two ways in from a host: a two-wire I2C-compatible bus or a four-wire SPI link. Both run over the same pins. It comes out of reset as an I2C slave. The first falling edge on the active-low chip-select moves it into SPI mode, and it stays there until the next reset. Either bus can write and read bytes. The register pointer advances by one after each data byte, so a long transfer sweeps through consecutive registers.

On the register side the block drives an address, write data and a one-cycle write strobe, and takes combinational read data back. All bus pins are sampled by the system clock through two-flop synchronisers. Edges are found by comparing the last two synchronised samples, so the system clock must run at least eight times faster than the fastest bus clock. I2C acknowledge and read bits leave the block as an open-drain pull-down enable. The SPI serial output comes with its own output enable, which stands for the high-impedance state.

Top module: `dual_bus_reg_slave`

## Requirements
- R1: After reset the block is in I2C mode. The first high-to-low edge of `cs_ni` puts it in SPI mode, and it remains there until `rst_ni` is asserted again. While in reset, `sda_oe_o`, `so_oe_o` and `reg_we_o` are 0.
- R2: The block answers only the 7-bit I2C address 0x16 when `asel_i` is 0, and only 0x17 when `asel_i` is 1. Any other address gets no acknowledge, and the block ignores the bus until the next START or STOP.
- R3: In an I2C write, the first byte after an address with R/W=0 sets the register pointer. Each later byte is written to the pointer, and the pointer then increments. The slave pulls SDA low during the ninth clock of every accepted byte.
- R4: In an I2C read, a repeated START with R/W=1 returns bytes from the pointer, then from pointer+1 and onward, MSB first. A master ACK fetches the next byte. A master NACK ends the read.
- R5: SPI works in clock mode 0 and in mode 3. SI is sampled on the rising SCK edge, MSB first. In the first byte after chip-select falls, bit 7 is the direction (1 = read, 0 = write) and bits [ADDR_W-1:0] give the register address.
- R6: In an SPI write, every byte after the command byte is written to the current pointer, and the pointer then increments. This continues for as long as `cs_ni` stays low.
- R7: In an SPI read, bytes from consecutive registers are shifted out on SO, MSB first. SO changes on falling SCK edges, so each bit is valid at the next rising edge.
- R8: `so_oe_o` is 1 only while read data is being shifted out in SPI mode. It is 0 while `cs_ni` is high, during the command byte, and in writes.
- R9: The register pointer wraps modulo 2^ADDR_W when it auto-increments (ADDR_W at most 7).
- R10: Each accepted data byte raises `reg_we_o` for exactly one system clock, with `reg_addr_o` and `reg_wdata_o` valid in that same cycle.
- R11: In SPI mode, I2C traffic gets no acknowledge, and `sda_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_sck_i | input | 1 | I2C SCL or SPI SCK |
| sda_si_i | input | 1 | I2C SDA line level or SPI SI |
| cs_ni | input | 1 | SPI chip select, active low; its first fall selects SPI |
| asel_i | input | 1 | I2C address select strap |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | SPI SO drive enable; 0 means high impedance |
| reg_addr_o | output | ADDR_W | Register file address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
The bench targets four things:
- The end of the register space. Auto-increment from the top register must land on register 0 in I2C writes, I2C reads and SPI reads. A pointer that saturates or spills into a wider field would send the next byte to the wrong register.
- A foreign I2C address. A slave that still acknowledged it, or woke up on a later byte, would show an ACK or an unexpected write strobe.
- The mode switch. I2C traffic after chip-select has fallen must go unanswered. The block must come back as an I2C slave after reset. A mode flag that was not sticky, or not cleared by reset, fails one of these.
- SO timing in both SPI clock modes. If the first data bit is driven too late in mode 3, or if the output is enabled during the command byte, the master sees corrupt data or a driven line where it expects high impedance.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int BYTE_W = 8;
  // upper six bits of the 7-bit slave address; the strap supplies bit 0
  localparam logic [5:0] I2C_ADDR_HI = 6'b001011;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_REGA, I_WDAT, I_ACK, I_RDAT, I_MACK
  } i2c_st_e;
endpackage

// File: rtl/dbs_pin_sync.sv
module dbs_pin_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o      = s2_q;
  assign q_prev_o = s3_q;
endmodule

// File: rtl/dbs_i2c_engine.sv
module dbs_i2c_engine
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              asel_i,
  input  logic              scl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              sda_oe_o
);
  i2c_st_e           st_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q;
  logic [ADDR_W-1:0] ptr_q, waddr_q;
  logic              we_q, oe_q;
  logic              start_c, stop_c;

  assign start_c = scl_i & sda_fall_i;
  assign stop_c  = scl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= I_IDLE;
      nxt_q   <= I_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      waddr_q <= '0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (!en_i) begin
        st_q <= I_IDLE;
        oe_q <= 1'b0;
      end else if (start_c) begin
        st_q  <= I_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_c) begin
        st_q <= I_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          I_ADDR, I_REGA, I_WDAT: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == I_ADDR) begin
                if (sh_q[7:1] == {I2C_ADDR_HI, asel_i}) begin
                  oe_q  <= 1'b1;
                  st_q  <= I_ACK;
                  nxt_q <= sh_q[0] ? I_RDAT : I_REGA;
                end else begin
                  st_q <= I_IDLE;
                end
              end else begin
                if (st_q == I_REGA) begin
                  ptr_q <= sh_q[ADDR_W-1:0];
                end else begin
                  we_q    <= 1'b1;
                  waddr_q <= ptr_q;
                  wdata_q <= sh_q;
                  ptr_q   <= ptr_q + 1'b1;
                end
                oe_q  <= 1'b1;
                st_q  <= I_ACK;
                nxt_q <= I_WDAT;
              end
            end
          end
          I_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              st_q  <= nxt_q;
              if (nxt_q == I_RDAT) begin
                tx_q <= rdata_i;
                oe_q <= ~rdata_i[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          I_RDAT: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
                st_q  <= I_MACK;
              end else begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~tx_q[BYTE_W-2];
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          I_MACK: begin
            if (scl_rise_i) begin
              if (sda_i) begin
                st_q <= I_IDLE;
              end else begin
                ptr_q <= ptr_q + 1'b1;
                st_q  <= I_ACK;
                nxt_q <= I_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o   = we_q ? waddr_q : ptr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/dbs_spi_engine.sv
module dbs_spi_engine
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              so_o,
  output logic              drive_o
);
  logic [2:0]        cnt_q;
  logic              first_q, rd_q, drv_q, we_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q;
  logic [ADDR_W-1:0] ptr_q, waddr_q;
  logic [BYTE_W-1:0] sh_n;

  assign sh_n = {sh_q[BYTE_W-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      rd_q    <= 1'b0;
      drv_q   <= 1'b0;
      we_q    <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      waddr_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (cs_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
        rd_q    <= 1'b0;
        drv_q   <= 1'b0;
      end else begin
        if (sck_rise_i) begin
          sh_q  <= sh_n;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (first_q) begin
              first_q <= 1'b0;
              rd_q    <= sh_n[BYTE_W-1];
              ptr_q   <= sh_n[ADDR_W-1:0];
            end else if (rd_q) begin
              ptr_q <= ptr_q + 1'b1;
            end else begin
              we_q    <= 1'b1;
              waddr_q <= ptr_q;
              wdata_q <= sh_n;
              ptr_q   <= ptr_q + 1'b1;
            end
          end
        end
        if (sck_fall_i && rd_q) begin
          drv_q <= 1'b1;
          if (cnt_q == 3'd0) tx_q <= rdata_i;
          else               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign addr_o  = we_q ? waddr_q : ptr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign so_o    = tx_q[BYTE_W-1];
  assign drive_o = drv_q;
endmodule

// File: rtl/dual_bus_reg_slave.sv
module dual_bus_reg_slave
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_sck_i,
  input  logic              sda_si_i,
  input  logic              cs_ni,
  input  logic              asel_i,
  output logic              sda_oe_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] pin_q, pin_prev;
  logic              scl_s, sda_s, cs_s;
  logic              scl_rise, scl_fall, sda_rise, sda_fall, cs_fall;
  logic              spi_mode_q;

  logic [ADDR_W-1:0] i_addr, s_addr;
  logic [BYTE_W-1:0] i_wdata, s_wdata;
  logic              i_we, s_we, s_so, s_drv;

  dbs_pin_sync #(.W(N_PINS), .RST_VAL('1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({cs_ni, sda_si_i, scl_sck_i}),
    .q_o     (pin_q),
    .q_prev_o(pin_prev)
  );

  assign scl_s    = pin_q[0];
  assign sda_s    = pin_q[1];
  assign cs_s     = pin_q[2];
  assign scl_rise = pin_q[0] & ~pin_prev[0];
  assign scl_fall = ~pin_q[0] & pin_prev[0];
  assign sda_rise = pin_q[1] & ~pin_prev[1];
  assign sda_fall = ~pin_q[1] & pin_prev[1];
  assign cs_fall  = ~pin_q[2] & pin_prev[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      spi_mode_q <= 1'b0;
    else if (cs_fall) spi_mode_q <= 1'b1;
  end

  dbs_i2c_engine #(.ADDR_W(ADDR_W)) u_i2c (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (~spi_mode_q),
    .asel_i    (asel_i),
    .scl_i     (scl_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_s),
    .sda_rise_i(sda_rise),
    .sda_fall_i(sda_fall),
    .rdata_i   (reg_rdata_i),
    .addr_o    (i_addr),
    .wdata_o   (i_wdata),
    .we_o      (i_we),
    .sda_oe_o  (sda_oe_o)
  );

  dbs_spi_engine #(.ADDR_W(ADDR_W)) u_spi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_s),
    .sck_rise_i(scl_rise),
    .sck_fall_i(scl_fall),
    .si_i      (sda_s),
    .rdata_i   (reg_rdata_i),
    .addr_o    (s_addr),
    .wdata_o   (s_wdata),
    .we_o      (s_we),
    .so_o      (s_so),
    .drive_o   (s_drv)
  );

  assign reg_addr_o  = spi_mode_q ? s_addr  : i_addr;
  assign reg_wdata_o = spi_mode_q ? s_wdata : i_wdata;
  assign reg_we_o    = spi_mode_q ? s_we    : i_we;
  assign so_o        = s_so;
  assign so_oe_o     = spi_mode_q & ~cs_s & s_drv;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_mode_i,
  input logic cs_s_i,
  input logic sda_oe_i,
  input logic so_oe_i,
  input logic we_i
);
  p_mode_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_i |=> spi_mode_i);

  p_so_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_i |-> (spi_mode_i && !cs_s_i));

  p_write_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !so_oe_i);

  p_we_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i);

  p_i2c_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_mode_i && $past(spi_mode_i)) |-> !sda_oe_i);
endmodule

bind dual_bus_reg_slave dbs_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .spi_mode_i(spi_mode_q),
  .cs_s_i    (cs_s),
  .sda_oe_i  (sda_oe_o),
  .so_oe_i   (so_oe_o),
  .we_i      (reg_we_o)
);

// File: tb/dual_bus_reg_slave_test.sv
module dual_bus_reg_slave_test;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, m_cs = 1'b1, asel = 1'b0;
  logic sda_oe, so, so_oe, we;
  logic [AW-1:0] raddr;
  logic [7:0] wdata, rdata;
  logic sda_pin;
  logic [7:0] mem [NREG];
  logic [7:0] shadow [NREG];
  logic [11:0] wq [$];
  logic [7:0] rq [$];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign sda_pin = m_sda & ~sda_oe;
  assign rdata   = mem[raddr];

  dual_bus_reg_slave #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_sck_i(m_scl), .sda_si_i(sda_pin),
    .cs_ni(m_cs), .asel_i(asel), .sda_oe_o(sda_oe), .so_o(so), .so_oe_o(so_oe),
    .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write monitor: pops the scoreboard on each strobe (R10)
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (wq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: got unexpected write %h@%h expected none", wdata, raddr);
      end else begin
        chk("R10 write addr/data", {4'h0, raddr, wdata}, {4'h0, wq.pop_front()});
      end
      mem[raddr] = wdata;
    end
  end

  function automatic void exp_write(input logic [AW-1:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    shadow[a] = d;
  endfunction

  // ---------- I2C master ----------
  task automatic i2c_start();
    m_sda = 1'b1; hw(HP); m_scl = 1'b1; hw(HP);
    m_sda = 1'b0; hw(HP); m_scl = 1'b0; hw(HP);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hw(HP); m_scl = 1'b1; hw(HP); m_sda = 1'b1; hw(HP);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(HP); m_scl = 1'b1; hw(HP); m_scl = 1'b0;
    end
    hw(HP/2); m_sda = 1'b1; hw(HP/2);
    m_scl = 1'b1; hw(HP/2); ack = ~sda_pin; hw(HP/2);
    m_scl = 1'b0; hw(HP/2);
  endtask

  task automatic i2c_rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(HP); m_scl = 1'b1; hw(HP/2); b[i] = sda_pin; hw(HP/2); m_scl = 1'b0;
    end
    hw(HP/2); m_sda = ~mack; hw(HP/2);
    m_scl = 1'b1; hw(HP); m_scl = 1'b0; hw(HP/2); m_sda = 1'b1;
  endtask

  task automatic i2c_write(input logic [6:0] dev, input logic [7:0] ra,
                           input int n, input logic [7:0] d0, input string req);
    logic ack;
    i2c_start();
    i2c_wbyte({dev, 1'b0}, ack); chk({req, " addr ack"}, ack, 1'b1);
    i2c_wbyte(ra, ack);          chk({req, " reg ack"}, ack, 1'b1);
    for (int k = 0; k < n; k++) begin
      exp_write(AW'(ra + k), d0 + 8'(k * 37));
      i2c_wbyte(d0 + 8'(k * 37), ack); chk({req, " data ack"}, ack, 1'b1);
    end
    i2c_stop();
  endtask

  task automatic i2c_read(input logic [6:0] dev, input logic [7:0] ra,
                          input int n, input string req);
    logic ack;
    logic [7:0] b;
    i2c_start();
    i2c_wbyte({dev, 1'b0}, ack); chk({req, " addr ack"}, ack, 1'b1);
    i2c_wbyte(ra, ack);          chk({req, " reg ack"}, ack, 1'b1);
    i2c_start();
    i2c_wbyte({dev, 1'b1}, ack); chk({req, " raddr ack"}, ack, 1'b1);
    for (int k = 0; k < n; k++) begin
      rq.push_back(shadow[AW'(ra + k)]);
      i2c_rbyte(k != n - 1, b);
      chk({req, " read data"}, b, rq.pop_front());
    end
    i2c_stop();
  endtask

  // ---------- SPI master ----------
  task automatic spi_byte(input logic cpol, input logic [7:0] din,
                          input logic cmd, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      if (cpol) m_scl = 1'b0;
      m_sda = din[i]; hw(HP);
      dout[i] = so;
      if (cmd) chk("R8 SO released in command", so_oe, 1'b0);
      else if (din == 8'h00 && i == 7) chk("R8 SO driven in read", so_oe, 1'b1);
      m_scl = 1'b1; hw(HP);
      if (!cpol) m_scl = 1'b0;
    end
  endtask

  task automatic spi_begin(input logic cpol);
    m_scl = cpol; hw(HP); m_cs = 1'b0; hw(HP);
  endtask

  task automatic spi_end();
    hw(HP); m_cs = 1'b1; hw(HP);
    chk("R8 SO released with cs high", so_oe, 1'b0);
  endtask

  task automatic spi_read(input logic cpol, input logic [6:0] ra,
                          input int n, input string req);
    logic [7:0] b;
    spi_begin(cpol);
    spi_byte(cpol, {1'b1, ra}, 1'b1, b);
    for (int k = 0; k < n; k++) begin
      rq.push_back(shadow[AW'(ra + k)]);
      spi_byte(cpol, 8'h00, 1'b0, b);
      chk(req, b, rq.pop_front());
    end
    spi_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) begin
      mem[i] = 8'(i * 17 + 3);
      shadow[i] = 8'(i * 17 + 3);
    end
    hw(4);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    chk("R1 reset so_oe", so_oe, 1'b0);
    chk("R1 reset we", we, 1'b0);
    rst_n = 1'b1; hw(4);

    // R3: write burst, strap low -> 0x16
    i2c_write(7'h16, 8'h03, 3, 8'h41, "R3");
    // R4: sequential read with repeated start
    i2c_read(7'h16, 8'h03, 3, "R4");

    // R2: foreign address is ignored
    i2c_start();
    i2c_wbyte({7'h17, 1'b0}, ack); chk("R2 foreign addr nack", ack, 1'b0);
    i2c_wbyte(8'h05, ack);         chk("R2 ignored byte nack", ack, 1'b0);
    i2c_wbyte(8'hAA, ack);         chk("R2 ignored data nack", ack, 1'b0);
    i2c_stop();

    // R2 strap high -> 0x17; R9 wrap on write and read
    asel = 1'b1; hw(HP);
    i2c_start();
    i2c_wbyte({7'h16, 1'b0}, ack); chk("R2 0x16 rejected with strap high", ack, 1'b0);
    i2c_stop();
    i2c_write(7'h17, 8'h0F, 2, 8'hA5, "R9 wrap write");
    i2c_read(7'h17, 8'h0F, 3, "R9 wrap read");
    asel = 1'b0;

    // R1/R5/R6: switch to SPI, mode 0 write
    m_sda = 1'b1; hw(HP); m_scl = 1'b0; hw(HP);
    spi_begin(1'b0);
    spi_byte(1'b0, 8'h02, 1'b1, b);
    exp_write(AW'(2), 8'h11); spi_byte(1'b0, 8'h11, 1'b0, b);
    exp_write(AW'(3), 8'h22); spi_byte(1'b0, 8'h22, 1'b0, b);
    spi_end();
    // R5/R6 mode 3 write wrapping
    spi_begin(1'b1);
    spi_byte(1'b1, 8'h0F, 1'b1, b);
    exp_write(AW'(15), 8'h3C); spi_byte(1'b1, 8'h3C, 1'b0, b);
    exp_write(AW'(0), 8'hC3);  spi_byte(1'b1, 8'hC3, 1'b0, b);
    spi_end();
    // R7 reads in both modes, R9 wrap
    spi_read(1'b1, 7'h0E, 3, "R7 mode3 read");
    spi_read(1'b0, 7'h02, 2, "R7 mode0 read");

    // R11: I2C is dead in SPI mode
    m_scl = 1'b1; m_sda = 1'b1; hw(HP);
    i2c_start();
    i2c_wbyte({7'h16, 1'b0}, ack); chk("R11 no ack in SPI mode", ack, 1'b0);
    i2c_wbyte(8'h01, ack);         chk("R11 no ack on data", ack, 1'b0);
    i2c_stop();
    chk("R11 no pending writes", 16'(wq.size()), 16'd0);

    // R1: reset returns to I2C mode
    rst_n = 1'b0; hw(2);
    chk("R1 reset so_oe", so_oe, 1'b0);
    rst_n = 1'b1; hw(4);
    i2c_write(7'h16, 8'h07, 1, 8'h77, "R1 I2C after reset");
    i2c_read(7'h16, 8'h07, 1, "R1 I2C read after reset");
    hw(HP);
    chk("R10 all writes seen", 16'(wq.size()), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule